// File: doc/BRIEF.md
# Keyed Watchdog Timer Controller

This block is a watchdog timer that runs from a slow, free-running clock. Software must restart it before it overflows. If it does not, the block asks for a reset. The enable is a 5-bit key rather than a single bit. Only two key patterns let the timer run. Writing any other pattern arms a short fixed delay, after which a full system reset is requested. That event also sets a sticky status flag that only software can clear.

The time-out comes from a fixed binary prescaler followed by a selectable tap. A 3-bit select gives a period of 2^(PRE_STAGES+sel) watchdog clock cycles. The clear-instruction strobe and the halt strobe both restart the count. A configuration write also restarts it. In run mode an overflow requests a full system reset. In sleep or idle mode it requests only a core reset (program counter and stack). In both modes it sets a time-out flag.

Top module: `keyed_wdog`

## Requirements
- R1: After power-on reset the key holds 01010b and the select holds 0, so the timer runs. With no writes and no clears, `sys_rst_req` pulses after 2^PRE_STAGES clock edges. Writing the key 01010b or 10101b keeps the timer running and arms no reset.
- R2: A write with any key other than 01010b and 10101b makes `sys_rst_req` pulse exactly SRST_DLY clock edges after the write edge. Later writes before that pulse neither cancel nor restart the delay. While the delay is pending, the timer does not count.
- R3: `swrst_flag` goes to 1 in the same cycle as the reset pulse caused by an illegal key. It survives clears, halts and later resets. Only `swrf_clr` clears it, and a set in the same cycle wins over the clear.
- R4: An overflow is signalled 2^(PRE_STAGES+sel) edges after the last restart of the count, where sel is `cfg_sel` as last written.
- R5: With `low_power` = 0, an overflow gives a one-cycle `sys_rst_req` and sets `to_flag`.
- R6: With `low_power` = 1, an overflow gives a one-cycle `core_rst_req` instead, and sets `to_flag`. Key and select are left unchanged.
- R7: `clr_wdt` or `halt` restarts the count and clears `to_flag`. If a strobe falls in the cycle where the overflow would occur, the strobe wins and no reset is requested.
- R8: A configuration write restarts the count, and the new select applies from that write onward.
- R9: After any `sys_rst_req`, the key and the select return to 01010b and 0 and the count restarts. Both flags keep their values.
- R10: Each reset request lasts one cycle, and `sys_rst_req` and `core_rst_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock (slow oscillator) |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_we | input | 1 | Write strobe for key and select |
| cfg_key | input | 5 | Key value written |
| cfg_sel | input | 3 | Time-out select written |
| clr_wdt | input | 1 | Clear-watchdog instruction strobe |
| halt | input | 1 | Halt instruction strobe |
| low_power | input | 1 | 1 while the core is in sleep or idle mode |
| swrf_clr | input | 1 | Software clear of the software-reset flag |
| sys_rst_req | output | 1 | One-cycle full system reset request |
| core_rst_req | output | 1 | One-cycle core-only reset request |
| to_flag | output | 1 | Time-out status flag |
| swrst_flag | output | 1 | Illegal-key reset status flag |

## Verification
Two pairs of events can land on the same edge. The first pair is a clear or halt strobe and the counter overflow. The bench counts edges from a write and raises `clr_wdt` so that it is sampled on exactly the edge that would overflow. It then expects no request on that edge and a fresh full period after it. The second pair is the setting of `swrst_flag` by an illegal-key reset and a software clear of that flag. The bench places `swrf_clr` on the firing edge of a pending illegal-key delay and expects the flag to read 1 afterward.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int KEY_W = 5;
  localparam logic [KEY_W-1:0] KEY_RUN_A = 5'b01010;
  localparam logic [KEY_W-1:0] KEY_RUN_B = 5'b10101;
  localparam logic [KEY_W-1:0] KEY_POR   = KEY_RUN_A;

  function automatic logic key_is_legal(input logic [KEY_W-1:0] k);
    return (k == KEY_RUN_A) || (k == KEY_RUN_B);
  endfunction
endpackage

// File: rtl/wdog_keyguard.sv
module wdog_keyguard
  import wdog_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int SRST_DLY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [KEY_W-1:0] cfg_key,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             restore,
  output logic [SEL_W-1:0] sel_q,
  output logic             run_en,
  output logic             sw_fire
);
  localparam int DW = (SRST_DLY > 1) ? $clog2(SRST_DLY) : 1;

  logic [KEY_W-1:0] key_q;
  logic             armed;
  logic [DW-1:0]    dly;
  logic             bad_wr;

  assign bad_wr  = cfg_we && !key_is_legal(cfg_key) && !restore;
  assign sw_fire = armed && (dly == '0);
  assign run_en  = key_is_legal(key_q) && !armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= KEY_POR;
      sel_q <= '0;
      armed <= 1'b0;
      dly   <= '0;
    end else begin
      if (restore) begin
        key_q <= KEY_POR;
        sel_q <= '0;
      end else if (cfg_we) begin
        key_q <= cfg_key;
        sel_q <= cfg_sel;
      end
      if (sw_fire) begin
        armed <= 1'b0;
      end else if (armed) begin
        dly <= dly - 1'b1;
      end else if (bad_wr) begin
        armed <= 1'b1;
        dly   <= DW'(SRST_DLY - 1);
      end
    end
  end
endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
  parameter int PRE_STAGES = 8,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             ovf
);
  localparam int TAPS = 1 << SEL_W;
  localparam int CW   = PRE_STAGES + TAPS - 1;

  logic [CW-1:0]   cnt;
  logic [TAPS-1:0] hit;

  genvar i;
  generate
    for (i = 0; i < TAPS; i++) begin : g_tap
      assign hit[i] = &cnt[PRE_STAGES+i-1:0];
    end
  endgenerate

  assign ovf = run_en && !restart && hit[sel];

  always_ff @(posedge clk) begin
    if (rst || restart || !run_en || ovf) cnt <= '0;
    else                                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst,
  input  logic tout,
  input  logic low_power,
  input  logic sw_fire,
  input  logic to_clr,
  input  logic swrf_clr,
  output logic sys_rst_req,
  output logic core_rst_req,
  output logic to_flag,
  output logic swrst_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_req  <= 1'b0;
      core_rst_req <= 1'b0;
      to_flag      <= 1'b0;
      swrst_flag   <= 1'b0;
    end else begin
      sys_rst_req  <= sw_fire || (tout && !low_power);
      core_rst_req <= tout && low_power;
      if (tout)        to_flag <= 1'b1;
      else if (to_clr) to_flag <= 1'b0;
      if (sw_fire)       swrst_flag <= 1'b1;
      else if (swrf_clr) swrst_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int PRE_STAGES = 8,
  parameter int SEL_W      = 3,
  parameter int SRST_DLY   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [4:0]       cfg_key,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             clr_wdt,
  input  logic             halt,
  input  logic             low_power,
  input  logic             swrf_clr,
  output logic             sys_rst_req,
  output logic             core_rst_req,
  output logic             to_flag,
  output logic             swrst_flag
);
  logic [SEL_W-1:0] sel_q;
  logic             run_en;
  logic             sw_fire;
  logic             tout;
  logic             restart;
  logic             restore;

  assign restart = clr_wdt || halt || cfg_we || sw_fire;
  assign restore = sw_fire || (tout && !low_power);

  wdog_keyguard #(.SEL_W(SEL_W), .SRST_DLY(SRST_DLY)) u_key (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_key(cfg_key),
    .cfg_sel(cfg_sel), .restore(restore), .sel_q(sel_q),
    .run_en(run_en), .sw_fire(sw_fire)
  );

  wdog_timebase #(.PRE_STAGES(PRE_STAGES), .SEL_W(SEL_W)) u_tb (
    .clk(clk), .rst(rst), .run_en(run_en), .restart(restart),
    .sel(sel_q), .ovf(tout)
  );

  wdog_status u_st (
    .clk(clk), .rst(rst), .tout(tout), .low_power(low_power),
    .sw_fire(sw_fire), .to_clr(clr_wdt || halt), .swrf_clr(swrf_clr),
    .sys_rst_req(sys_rst_req), .core_rst_req(core_rst_req),
    .to_flag(to_flag), .swrst_flag(swrst_flag)
  );
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk (
  input logic clk,
  input logic rst,
  input logic clr_wdt,
  input logic halt,
  input logic low_power,
  input logic swrf_clr,
  input logic sys_rst_req,
  input logic core_rst_req,
  input logic to_flag,
  input logic swrst_flag
);
  // R10
  req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(sys_rst_req && core_rst_req));
  // R10
  sys_single_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> !sys_rst_req);
  // R10
  core_single_chk: assert property (@(posedge clk) disable iff (rst)
    core_rst_req |=> !core_rst_req);
  // R6
  core_needs_lp_chk: assert property (@(posedge clk) disable iff (rst)
    core_rst_req |-> $past(low_power));
  // R7
  clear_blocks_core_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr_wdt || halt) |-> !core_rst_req);
  // R5
  to_rise_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(to_flag) |-> (sys_rst_req || core_rst_req));
  // R3
  swrf_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(swrst_flag) |-> $past(swrf_clr));
  // R3
  swrf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(swrst_flag) |-> sys_rst_req);
endmodule

bind keyed_wdog keyed_wdog_chk u_chk (
  .clk(clk), .rst(rst), .clr_wdt(clr_wdt), .halt(halt),
  .low_power(low_power), .swrf_clr(swrf_clr),
  .sys_rst_req(sys_rst_req), .core_rst_req(core_rst_req),
  .to_flag(to_flag), .swrst_flag(swrst_flag)
);

// File: tb/keyed_wdog_test.sv
`timescale 1ns/1ps
module keyed_wdog_test;
  localparam int PRE = 3;
  localparam logic [4:0] KA = 5'b01010;
  localparam logic [4:0] KB = 5'b10101;
  // {sel[2:0], low_power}
  localparam logic [3:0] VEC [0:7] = '{4'b000_0, 4'b011_1, 4'b001_0, 4'b101_1,
                                       4'b010_1, 4'b110_0, 4'b100_1, 4'b111_0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_key = '0;
  logic [2:0] cfg_sel = '0;
  logic clr_wdt = 1'b0, halt = 1'b0, low_power = 1'b0, swrf_clr = 1'b0;
  logic sys_rst_req, core_rst_req, to_flag, swrst_flag;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyed_wdog #(.PRE_STAGES(PRE)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_key(cfg_key), .cfg_sel(cfg_sel),
    .clr_wdt(clr_wdt), .halt(halt), .low_power(low_power), .swrf_clr(swrf_clr),
    .sys_rst_req(sys_rst_req), .core_rst_req(core_rst_req),
    .to_flag(to_flag), .swrst_flag(swrst_flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] k, input logic [2:0] s);
    cfg_we = 1'b1; cfg_key = k; cfg_sel = s;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic run_until(input int maxn, output int n, output int s, output int c);
    n = 0; s = 0; c = 0;
    while (n == 0 && maxn > 0) begin
      step();
      maxn--;
      if (sys_rst_req || core_rst_req) begin
        s = int'(sys_rst_req); c = int'(core_rst_req); n = -1;
      end else if (maxn == 0) n = -2;
      if (n == 0) n = 0;
    end
  endtask

  // counts edges until the first request; returns 0 if none
  task automatic edges_to_req(input int maxn, output int n, output int s, output int c);
    n = 0; s = 0; c = 0;
    for (int i = 1; i <= maxn; i++) begin
      step();
      if ((sys_rst_req || core_rst_req) && n == 0) begin
        n = i; s = int'(sys_rst_req); c = int'(core_rst_req);
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, s, c, cnt;
    // reset state
    repeat (3) step();
    chk("R1", "sys after reset", int'(sys_rst_req), 0);
    chk("R1", "core after reset", int'(core_rst_req), 0);
    chk("R1", "to_flag after reset", int'(to_flag), 0);
    chk("R3", "swrst_flag after reset", int'(swrst_flag), 0);
    rst = 1'b0;
    edges_to_req(40, n, s, c);
    chk("R1", "default period", n, 1 << PRE);
    chk("R5", "default sys", s, 1);

    // vector table: period and kind per select and mode
    for (int v = 0; v < 8; v++) begin
      int sl, lp, L;
      sl = int'(VEC[v][3:1]); lp = int'(VEC[v][0]); L = (1 << PRE) << sl;
      low_power = VEC[v][0];
      clr_wdt = 1'b1;
      wr((v % 2) ? KB : KA, VEC[v][3:1]);
      clr_wdt = 1'b0;
      chk("R7", "to_flag cleared", int'(to_flag), 0);
      edges_to_req(L + 4, n, s, c);
      chk("R4", "period", n, L);
      chk(lp ? "R6" : "R5", "sys kind", s, 1 - lp);
      chk(lp ? "R6" : "R5", "core kind", c, lp);
      chk(lp ? "R6" : "R5", "to_flag set", int'(to_flag), 1);
      step();
      chk("R10", "pulse width", int'(sys_rst_req || core_rst_req), 0);
    end
    low_power = 1'b0;

    // regular clears keep it quiet
    wr(KB, 3'd0);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (i % 4 == 3) begin clr_wdt = (i % 8 == 3); halt = (i % 8 != 3); end
      step();
      clr_wdt = 1'b0; halt = 1'b0;
      if (sys_rst_req || core_rst_req) cnt++;
    end
    chk("R7", "requests with clears", cnt, 0);

    // clear on the overflow edge wins
    wr(KA, 3'd0);
    repeat ((1 << PRE) - 1) step();
    clr_wdt = 1'b1;
    step();
    clr_wdt = 1'b0;
    chk("R7", "coincident clear suppresses", int'(sys_rst_req), 0);
    chk("R7", "to_flag after coincident clear", int'(to_flag), 0);
    edges_to_req(40, n, s, c);
    chk("R7", "period after coincident clear", n, 1 << PRE);

    // halt clears time-out flag
    halt = 1'b1; step(); halt = 1'b0;
    chk("R7", "halt clears to_flag", int'(to_flag), 0);

    // config write restarts count; new select immediate
    wr(KA, 3'd0);
    repeat (5) step();
    wr(KA, 3'd0);
    edges_to_req(40, n, s, c);
    chk("R8", "rewrite restarts", n, 1 << PRE);
    wr(KA, 3'd0);
    repeat (5) step();
    wr(KA, 3'd2);
    edges_to_req(100, n, s, c);
    chk("R8", "new select period", n, (1 << PRE) << 2);

    // legal keys arm nothing
    wr(KA, 3'd7);
    edges_to_req(20, n, s, c);
    chk("R1", "legal key A no reset", n, 0);
    wr(KB, 3'd7);
    edges_to_req(20, n, s, c);
    chk("R1", "legal key B no reset", n, 0);
    chk("R3", "swrst_flag after legal keys", int'(swrst_flag), 0);

    // illegal key: delayed reset, flag, restore
    wr(5'b11111, 3'd7);
    edges_to_req(20, n, s, c);
    chk("R2", "illegal key delay", n, 4);
    chk("R2", "illegal key sys", s, 1);
    chk("R3", "swrst_flag set", int'(swrst_flag), 1);
    edges_to_req(40, n, s, c);
    chk("R9", "restored key and select period", n, 1 << PRE);
    chk("R9", "to_flag kept", int'(to_flag), 1);

    // pending delay is not cancelled by a legal write
    wr(5'b00000, 3'd3);
    wr(KA, 3'd3);
    edges_to_req(20, n, s, c);
    chk("R2", "delay not cancelled", n, 3);

    // sticky flag
    clr_wdt = 1'b1; step(); clr_wdt = 1'b0;
    halt = 1'b1; step(); halt = 1'b0;
    chk("R3", "swrst_flag survives clears", int'(swrst_flag), 1);
    swrf_clr = 1'b1; step(); swrf_clr = 1'b0;
    chk("R3", "swrst_flag cleared by software", int'(swrst_flag), 0);
    wr(5'b00110, 3'd0);
    repeat (3) step();
    swrf_clr = 1'b1; step(); swrf_clr = 1'b0;
    chk("R3", "set beats clear", int'(swrst_flag), 1);
    chk("R2", "sys on that edge", int'(sys_rst_req), 1);

    // full reset restores select; core reset keeps it
    wr(KA, 3'd4);
    edges_to_req(200, n, s, c);
    chk("R4", "sel4 period", n, (1 << PRE) << 4);
    edges_to_req(40, n, s, c);
    chk("R9", "select restored after sys", n, 1 << PRE);
    low_power = 1'b1;
    wr(KB, 3'd1);
    edges_to_req(40, n, s, c);
    chk("R6", "core period", n, (1 << PRE) << 1);
    edges_to_req(40, n, s, c);
    chk("R6", "select kept after core reset", n, (1 << PRE) << 1);
    chk("R6", "core kind repeat", c, 1);
    low_power = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule